// File: doc/BRIEF.md
# Prescaled Tick Divider with Event Counter

This block divides a slow tick-enable strobe by a programmable ratio and counts the results. It has three 32-bit registers: a reload value, a down-counting divider count, and an up-counting event count. Every cycle in which the tick-enable input is high, the divider count steps down by one. When a tick arrives while the divider count is already zero, the divider count takes the reload value and the event count steps up by one. A reload value of N therefore gives one event every N+1 ticks. A reload value of zero makes every tick an event.

Software reaches all three registers through a plain synchronous port made of an address, a write enable, write data and registered read data. A write replaces the register's value at once, and counting goes on from the written value. A write to the reload value only affects the next reload. It never changes the count in progress.

Top module: `presc_event_timer`

## Requirements
- R1: After reset, the reload value, the divider count, the event count and rd_data are all zero.
- R2: On a cycle with tick_en high and a nonzero divider count, the divider count drops by one and the event count holds. With tick_en low, neither count changes.
- R3: On a cycle with tick_en high and a divider count of zero, the divider count loads the reload value (as it stood before that edge) and the event count rises by one in the same cycle. The event period is therefore reload+1 ticks.
- R4: With a reload value of zero, the divider count stays at zero and the event count rises on every tick.
- R5: A divider count written above the reload value counts down from the written value. Only later reloads use the reload value.
- R6: A write to the reload value leaves the current divider count unchanged. The new value is used at the next reload.
- R7: A write to the divider count or the event count replaces its value directly, and counting continues from there.
- R8: The event count wraps modulo 2^32, so 0xFFFFFFFF plus one event gives 0.
- R9: When a write and a tick fall in the same cycle, the written register takes the write data. The other count still follows the tick.
- R10: The address map is 0 = reload value, 1 = divider count, 2 = event count. rd_data shows, one cycle after addr is presented, the value of that register as it stood before that edge. Address 3 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe from the slower reference clock |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the address of the previous cycle |

## Verification
A divider count that is off by even one shifts every later event by a cycle. It also shows at address 1 on the next read after the faulty tick. A wrong reload, such as taking the newly written value instead of the one before the edge, shows as a wrong divider count on the read straight after the wrap. An event count that misses, doubles or survives a write shows at address 2 one cycle after it is addressed. The simultaneous write-and-tick cases are driven on purpose, because an error in write priority is otherwise hidden.

// File: rtl/pet_pkg.sv
package pet_pkg;

  // Register indices; the offsets are part of the software contract.
  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_DOWN   = 2'd1,
    REG_EVENT  = 2'd2
  } reg_idx_e;

  // One write strobe per implemented register.
  typedef struct packed {
    logic reload;
    logic down;
    logic evt;
  } wr_strobe_t;

endpackage

// File: rtl/pet_addr_decode.sv
module pet_addr_decode #(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output pet_pkg::wr_strobe_t strb,
  output logic              addr_valid
);
  import pet_pkg::*;

  logic hit_reload;
  logic hit_down;
  logic hit_evt;

  always_comb begin
    hit_reload = (addr == ADDR_W'(REG_RELOAD));
    hit_down   = (addr == ADDR_W'(REG_DOWN));
    hit_evt    = (addr == ADDR_W'(REG_EVENT));
    addr_valid = hit_reload | hit_down | hit_evt;
    strb.reload = wr_en & hit_reload;
    strb.down   = wr_en & hit_down;
    strb.evt    = wr_en & hit_evt;
  end

endmodule

// File: rtl/pet_down_counter.sv
module pet_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);

  logic [CNT_W-1:0] count_q;

  // A tick at zero reloads the count; any other tick steps it down.
  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] cur,
                                                 input logic [CNT_W-1:0] rl);
    if (cur == '0) return rl;
    return cur - CNT_W'(1);
  endfunction

  assign wrap_evt = tick && (count_q == '0);
  assign count    = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr) begin
      count_q <= wr_data;
    end else if (tick) begin
      count_q <= step_down(count_q, reload);
    end
  end

endmodule

// File: rtl/pet_event_counter.sv
module pet_event_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;

  // Modulo-2^CNT_W increment.
  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] cur);
    return cur + CNT_W'(1);
  endfunction

  assign count = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (wr) begin
      count_q <= wr_data;
    end else if (wrap) begin
      count_q <= step_up(count_q);
    end
  end

endmodule

// File: rtl/pet_read_port.sv
module pet_read_port #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_valid,
  input  logic [CNT_W-1:0]  reload,
  input  logic [CNT_W-1:0]  down,
  input  logic [CNT_W-1:0]  evt,
  output logic [CNT_W-1:0]  rd_data
);
  import pet_pkg::*;

  logic [CNT_W-1:0] rd_q;

  function automatic logic [CNT_W-1:0] pick(input logic [ADDR_W-1:0] a,
                                            input logic              ok,
                                            input logic [CNT_W-1:0]  r,
                                            input logic [CNT_W-1:0]  d,
                                            input logic [CNT_W-1:0]  e);
    if (!ok) return '0;
    if (a == ADDR_W'(REG_RELOAD)) return r;
    if (a == ADDR_W'(REG_DOWN)) return d;
    return e;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= pick(addr, addr_valid, reload, down, evt);
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/presc_event_timer.sv
module presc_event_timer #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data
);
  import pet_pkg::*;

  wr_strobe_t       strb;
  logic             addr_valid;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] down_q;
  logic [CNT_W-1:0] evt_q;
  logic             wrap_evt;

  pet_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (addr),
    .wr_en      (wr_en),
    .strb       (strb),
    .addr_valid (addr_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)           reload_q <= '0;
    else if (strb.reload) reload_q <= wr_data;
  end

  pet_down_counter #(.CNT_W(CNT_W)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_en),
    .wr       (strb.down),
    .wr_data  (wr_data),
    .reload   (reload_q),
    .count    (down_q),
    .wrap_evt (wrap_evt)
  );

  pet_event_counter #(.CNT_W(CNT_W)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrap    (wrap_evt),
    .wr      (strb.evt),
    .wr_data (wr_data),
    .count   (evt_q)
  );

  pet_read_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .addr_valid (addr_valid),
    .reload     (reload_q),
    .down       (down_q),
    .evt        (evt_q),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/pet_checker.sv
module pet_checker #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [CNT_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  rd_data,
  input logic [CNT_W-1:0]  reload_q,
  input logic [CNT_W-1:0]  down_q,
  input logic [CNT_W-1:0]  evt_q,
  input logic              wrap_evt
);

  logic w_rl, w_dn, w_ev, a_bad;
  assign w_rl  = wr_en && (addr == ADDR_W'(0));
  assign w_dn  = wr_en && (addr == ADDR_W'(1));
  assign w_ev  = wr_en && (addr == ADDR_W'(2));
  assign a_bad = (addr == ADDR_W'(3));

  assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && down_q != '0 && !w_dn) |=> (down_q == $past(down_q) - CNT_W'(1)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> ($stable(down_q) && $stable(evt_q)));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && down_q == '0 && !w_dn) |=> (down_q == $past(reload_q)));

  assert_event_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !w_ev) |=> (evt_q == $past(evt_q) + CNT_W'(1)));

  assert_no_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap_evt && !w_ev) |=> $stable(evt_q));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_dn || w_ev || w_rl) |=> (($past(w_dn) -> down_q == $past(wr_data)) &&
                               ($past(w_ev) -> evt_q == $past(wr_data)) &&
                               ($past(w_rl) -> reload_q == $past(wr_data))));

  assert_hole_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_bad |=> (rd_data == '0));

  assert_read_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(1)) |=> (rd_data == $past(down_q)));

  assert_hole_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_bad && !tick_en) |=> ($stable(down_q) && $stable(evt_q) && $stable(reload_q)));

endmodule

bind presc_event_timer pet_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .reload_q (reload_q),
  .down_q   (down_q),
  .evt_q    (evt_q),
  .wrap_evt (wrap_evt)
);

// File: tb/presc_event_timer_bench.sv
module presc_event_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  presc_event_timer u_presc_event_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic tick_and_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    tick_en = 1'b1; addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); check("R1 reload", v, 0);
    rd(2'd1, v); check("R1 down", v, 0);
    rd(2'd2, v); check("R1 event", v, 0);
  endtask

  task automatic t_zero_reload;
    logic [31:0] v;
    ticks(3);
    rd(2'd1, v); check("R4 down sticks", v, 0);
    rd(2'd2, v); check("R4 event per tick", v, 3);
    repeat (4) @(negedge clk);
    rd(2'd2, v); check("R2 idle holds event", v, 3);
  endtask

  task automatic t_sequence;
    logic [31:0] v;
    int y, ed, ee;
    wr(2'd0, 5); wr(2'd1, 7); wr(2'd2, 0);
    for (int i = 1; i <= 14; i++) begin
      ticks(1);
      if (i < 7) begin ed = 7 - i; ee = 0; end
      else begin y = i - 2; ed = 5 - (y % 6); ee = y / 6; end
      rd(2'd1, v); check("R3/R5 down sequence", v, ed);
      rd(2'd2, v); check("R3 event sequence", v, ee);
    end
  endtask

  task automatic t_reload_write;
    logic [31:0] v;
    wr(2'd0, 5); wr(2'd1, 3); wr(2'd2, 0);
    wr(2'd0, 2);
    rd(2'd1, v); check("R6 count untouched", v, 3);
    ticks(3);
    rd(2'd1, v); check("R2 decrement to zero", v, 0);
    ticks(1);
    rd(2'd1, v); check("R6 new reload used", v, 2);
    rd(2'd2, v); check("R6 one event", v, 1);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 32'hFFFF_FFFF);
    ticks(1);
    rd(2'd2, v); check("R8 event wraps", v, 0);
    wr(2'd2, 32'd1234);
    rd(2'd2, v); check("R7 event overwrite", v, 1234);
    ticks(1);
    rd(2'd2, v); check("R7 counts on from written", v, 1235);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(2'd0, 4); wr(2'd1, 0); wr(2'd2, 10);
    tick_and_write(2'd1, 9);
    rd(2'd1, v); check("R9 down write wins", v, 9);
    rd(2'd2, v); check("R9 event still ticks", v, 11);
    wr(2'd1, 2);
    tick_and_write(2'd2, 50);
    rd(2'd2, v); check("R9 event write wins", v, 50);
    rd(2'd1, v); check("R9 down still ticks", v, 1);
    wr(2'd1, 0);
    tick_and_write(2'd0, 7);
    rd(2'd1, v); check("R9 reload before edge used", v, 4);
    rd(2'd0, v); check("R9 reload written", v, 7);
  endtask

  task automatic t_hole;
    logic [31:0] v;
    wr(2'd0, 3); wr(2'd1, 6); wr(2'd2, 8);
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, v); check("R10 hole reads zero", v, 0);
    rd(2'd0, v); check("R10 reload unchanged", v, 3);
    rd(2'd1, v); check("R10 down unchanged", v, 6);
    rd(2'd2, v); check("R10 event unchanged", v, 8);
    // read latency: value shown is the register before the tick edge
    @(negedge clk);
    addr = 2'd1; tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    check("R10 read before tick edge", rd_data, 6);
    @(negedge clk);
    check("R10 read after tick", rd_data, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_reload();
    t_sequence();
    t_reload_write();
    t_wrap();
    t_collide();
    t_hole();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule